// File: doc/BRIEF.md
# Floating-Point Condition Decision Unit

This block takes the condition flags of a floating-point unit and a 6-bit condition predicate. It decides whether the predicate holds, then turns that answer into the control decision for one of four kinds of conditional operation:

- a plain conditional branch;
- a loop branch that counts down a register;
- a set-byte-on-condition;
- a trap-on-condition.

The surrounding pipeline fetches the instruction, computes targets and raises exceptions. This block only supplies the decision, the updated loop count, the byte to store, the trap request and the number of extension words the trap form occupies.

Requests arrive on a valid/ready input stream, and each accepted request yields one result on a valid/ready output stream. A request is accepted on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the single result register is empty or is being drained in the same cycle. A result stays on the output, with all fields unchanged, until it is taken on an edge where `out_valid` and `out_ready` are both high. The predicate logic itself is combinational, and only the result stage holds state.

Top module: `fpcond_unit`

## Requirements
- R1: `in_flags` carries NaN in bit 0, infinity in bit 1, zero in bit 2 and negative in bit 3. The infinity bit never affects a result. Predicates 0x10-0x1F give the same result as the predicate with bit 4 cleared.
- R2: Predicates with bit 5 set (0x20-0x3F) raise `out_illegal_pred` and force `out_cond` to 0. All other predicates leave `out_illegal_pred` at 0.
- R3: Code 0x0 is always false and code 0xF is always true. Code 0x1 equals zero and code 0xE equals NOT zero. Code 0x7 equals NOT nan and code 0x8 equals nan.
- R4: The ordered codes follow these equations:
  - 0x2 is !neg & !zero & !nan;
  - 0x3 is zero | (!neg & !nan);
  - 0x4 is neg & !nan & !zero;
  - 0x5 is (neg & !nan) | zero;
  - 0x6 is !nan & !zero.
- R5: The unordered codes follow these equations:
  - 0x9 is nan | zero;
  - 0xA is nan | (!neg & !zero);
  - 0xB is nan | zero | !neg;
  - 0xC is nan | (neg & !zero);
  - 0xD is nan | zero | neg.
- R6: `in_op` selects the operation: 0 is branch, 1 is loop, 2 is set and 3 is trap. For branch, `out_take` equals `out_cond`. For any operation other than loop, `out_count` equals `in_count`.
- R7: For loop with a true condition, `out_take` is 0 and `out_count` equals `in_count`.
- R8: For loop with a false condition, the low 16 bits of the count are decremented modulo 2^16 and the upper 16 bits are kept. `out_take` is 1 unless the new low half is 0xFFFF.
- R9: For set, `out_set_byte` is 0xFF when the condition is true and 0x00 when it is false. For all other operations it is 0x00. `out_take` is 0 for set and trap.
- R10: For trap, `in_trap_mode` selects the extension words to skip: 2 gives 1, 3 gives 2 and 4 gives 0. Any other mode gives 0 and raises `out_bad_mode`. For other operations, `out_skip_words` and `out_bad_mode` are 0.
- R11: For trap, `out_trap` equals the condition, even when the mode is invalid. `out_trap_vec` is 7 while `out_trap` is 1 and 0 otherwise. `out_trap` is 0 for other operations.
- R12: A result appears on the output in the cycle after its request is accepted. It stays stable until it is consumed. Results leave in the order the requests were accepted. `in_ready` = !`out_valid` | `out_ready`.
- R13: While `rst_n` is low and after its release, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be accepted |
| in_op | input | 2 | Operation kind (0 branch, 1 loop, 2 set, 3 trap) |
| in_pred | input | 6 | Condition predicate |
| in_flags | input | 4 | Condition flags {neg, zero, inf, nan} |
| in_count | input | 32 | Loop count register value |
| in_trap_mode | input | 3 | Trap operand-size mode |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Result consumer ready |
| out_cond | output | 1 | Predicate result |
| out_take | output | 1 | Take the branch |
| out_count | output | 32 | Updated loop count |
| out_set_byte | output | 8 | Byte value for the set operation |
| out_trap | output | 1 | Trap request |
| out_trap_vec | output | 8 | Trap vector number |
| out_skip_words | output | 2 | Extension words to skip |
| out_illegal_pred | output | 1 | Reserved predicate seen |
| out_bad_mode | output | 1 | Invalid trap mode |

## Verification
Every result field is due exactly one clock after the edge that accepts its request, and it then holds until the edge where `out_ready` is seen high. The bench drives inputs and `out_ready` just after the falling edge and reads `in_ready` there. At that point it pushes the expected result into a queue. On every later falling edge with `out_valid` high, it compares the output against the queue head. The head is popped only when `out_ready` is high, so a stalled result is compared again on each stall cycle. This checks both the one-cycle latency and the hold-until-consumed rule.

// File: rtl/fpcond_pkg.sv
package fpcond_pkg;

  typedef enum logic [1:0] {
    OP_BRANCH = 2'd0,
    OP_LOOP   = 2'd1,
    OP_SET    = 2'd2,
    OP_TRAP   = 2'd3
  } fpc_op_e;

  localparam int FLAG_NAN  = 0;
  localparam int FLAG_INF  = 1;
  localparam int FLAG_ZERO = 2;
  localparam int FLAG_NEG  = 3;
  localparam int FLAG_W    = 4;
  localparam int BASE_CODES = 16;

  // Result of one of the sixteen base predicate codes.
  function automatic logic base_pred(input logic [3:0] code,
                                     input logic nan, input logic zero,
                                     input logic neg);
    logic r;
    case (code)
      4'h0: r = 1'b0;
      4'h1: r = zero;
      4'h2: r = !neg && !zero && !nan;
      4'h3: r = zero || (!neg && !nan);
      4'h4: r = neg && !nan && !zero;
      4'h5: r = (neg && !nan) || zero;
      4'h6: r = !nan && !zero;
      4'h7: r = !nan;
      4'h8: r = nan;
      4'h9: r = nan || zero;
      4'hA: r = nan || (!neg && !zero);
      4'hB: r = nan || zero || !neg;
      4'hC: r = nan || (neg && !zero);
      4'hD: r = nan || zero || neg;
      4'hE: r = !zero;
      default: r = 1'b1;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/fpcond_pred_eval.sv
module fpcond_pred_eval
  import fpcond_pkg::*;
#(
  parameter int PRED_W = 6
) (
  input  logic [PRED_W-1:0] pred,
  input  logic [FLAG_W-1:0] flags,
  output logic              cond,
  output logic              illegal
);
  localparam int RSV_LSB = 5;

  logic [BASE_CODES-1:0] hits;
  logic nan_f, zero_f, neg_f;

  assign nan_f  = flags[FLAG_NAN];
  assign zero_f = flags[FLAG_ZERO];
  assign neg_f  = flags[FLAG_NEG];

  // One evaluator per base code; bit 4 of the predicate is a mirror.
  for (genvar g = 0; g < BASE_CODES; g++) begin : g_code
    assign hits[g] = base_pred(4'(g), nan_f, zero_f, neg_f);
  end

  assign illegal = |pred[PRED_W-1:RSV_LSB];
  assign cond    = illegal ? 1'b0 : hits[pred[3:0]];

  always_comb begin
    if (pred[3:0] == 4'hF && !illegal)
      assert_true_code_R3: assert (cond);
    if (pred[3:0] == 4'h0)
      assert_false_code_R3: assert (!cond);
  end

endmodule

// File: rtl/fpcond_decide.sv
module fpcond_decide
  import fpcond_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int LOOP_W   = 16,
  parameter int VEC_W    = 8,
  parameter int TRAP_VEC = 7,
  parameter int MODE_W   = 3,
  parameter int SKIP_W   = 2,
  parameter int BYTE_W   = 8
) (
  input  fpc_op_e           op,
  input  logic              cond,
  input  logic [CNT_W-1:0]  count,
  input  logic [MODE_W-1:0] trap_mode,
  output logic              take,
  output logic [CNT_W-1:0]  count_nxt,
  output logic [BYTE_W-1:0] set_byte,
  output logic              trap,
  output logic [VEC_W-1:0]  trap_vec,
  output logic [SKIP_W-1:0] skip,
  output logic              bad_mode
);
  localparam logic [LOOP_W-1:0] LOOP_END = '1;
  localparam logic [MODE_W-1:0] MODE_WORD = MODE_W'(2);
  localparam logic [MODE_W-1:0] MODE_LONG = MODE_W'(3);
  localparam logic [MODE_W-1:0] MODE_NONE = MODE_W'(4);

  logic [LOOP_W-1:0] low_dec;
  logic [CNT_W-1:0]  loop_cnt;

  assign low_dec = count[LOOP_W-1:0] - 1'b1;

  generate
    if (CNT_W > LOOP_W) begin : g_upper
      assign loop_cnt = {count[CNT_W-1:LOOP_W], low_dec};
    end else begin : g_flat
      assign loop_cnt = low_dec;
    end
  endgenerate

  always_comb begin
    take      = 1'b0;
    count_nxt = count;
    set_byte  = '0;
    trap      = 1'b0;
    trap_vec  = '0;
    skip      = '0;
    bad_mode  = 1'b0;
    unique case (op)
      OP_BRANCH: take = cond;
      OP_LOOP: begin
        if (!cond) begin
          count_nxt = loop_cnt;
          take      = (low_dec != LOOP_END);
        end
      end
      OP_SET: set_byte = cond ? '1 : '0;
      OP_TRAP: begin
        case (trap_mode)
          MODE_WORD: skip = SKIP_W'(1);
          MODE_LONG: skip = SKIP_W'(2);
          MODE_NONE: skip = '0;
          default:   bad_mode = 1'b1;
        endcase
        trap     = cond;
        trap_vec = cond ? VEC_W'(TRAP_VEC) : '0;
      end
      default: ;
    endcase
  end

  always_comb begin
    if (op == OP_SET)
      assert_set_byte_R9: assert (set_byte == (cond ? {BYTE_W{1'b1}} : {BYTE_W{1'b0}}));
    if (op == OP_TRAP && bad_mode)
      assert_bad_skip_R10: assert (skip == '0);
  end

endmodule

// File: rtl/fpcond_unit.sv
module fpcond_unit
  import fpcond_pkg::*;
#(
  parameter int PRED_W   = 6,
  parameter int CNT_W    = 32,
  parameter int LOOP_W   = 16,
  parameter int VEC_W    = 8,
  parameter int TRAP_VEC = 7,
  parameter int MODE_W   = 3,
  parameter int SKIP_W   = 2,
  parameter int BYTE_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_op,
  input  logic [PRED_W-1:0] in_pred,
  input  logic [FLAG_W-1:0] in_flags,
  input  logic [CNT_W-1:0]  in_count,
  input  logic [MODE_W-1:0] in_trap_mode,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_cond,
  output logic              out_take,
  output logic [CNT_W-1:0]  out_count,
  output logic [BYTE_W-1:0] out_set_byte,
  output logic              out_trap,
  output logic [VEC_W-1:0]  out_trap_vec,
  output logic [SKIP_W-1:0] out_skip_words,
  output logic              out_illegal_pred,
  output logic              out_bad_mode
);
  logic              cond_w, illegal_w, take_w, trap_w, bad_w;
  logic [CNT_W-1:0]  count_w;
  logic [BYTE_W-1:0] byte_w;
  logic [VEC_W-1:0]  vec_w;
  logic [SKIP_W-1:0] skip_w;
  logic              accept;

  fpcond_pred_eval #(.PRED_W(PRED_W)) u_eval (
    .pred    (in_pred),
    .flags   (in_flags),
    .cond    (cond_w),
    .illegal (illegal_w)
  );

  fpcond_decide #(
    .CNT_W(CNT_W), .LOOP_W(LOOP_W), .VEC_W(VEC_W), .TRAP_VEC(TRAP_VEC),
    .MODE_W(MODE_W), .SKIP_W(SKIP_W), .BYTE_W(BYTE_W)
  ) u_decide (
    .op        (fpc_op_e'(in_op)),
    .cond      (cond_w),
    .count     (in_count),
    .trap_mode (in_trap_mode),
    .take      (take_w),
    .count_nxt (count_w),
    .set_byte  (byte_w),
    .trap      (trap_w),
    .trap_vec  (vec_w),
    .skip      (skip_w),
    .bad_mode  (bad_w)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_cond         <= 1'b0;
      out_take         <= 1'b0;
      out_count        <= '0;
      out_set_byte     <= '0;
      out_trap         <= 1'b0;
      out_trap_vec     <= '0;
      out_skip_words   <= '0;
      out_illegal_pred <= 1'b0;
      out_bad_mode     <= 1'b0;
    end else if (accept) begin
      out_cond         <= cond_w;
      out_take         <= take_w;
      out_count        <= count_w;
      out_set_byte     <= byte_w;
      out_trap         <= trap_w;
      out_trap_vec     <= vec_w;
      out_skip_words   <= skip_w;
      out_illegal_pred <= illegal_w;
      out_bad_mode     <= bad_w;
    end
  end

  assert_reset_idle_R13: assert property (@(posedge clk)
    !rst_n |=> !out_valid);

  assert_accept_latency_R12: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  assert_hold_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_cond) && $stable(out_take)
      && $stable(out_count) && $stable(out_trap) && $stable(out_set_byte));

  assert_loop_decrement_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_op == 2'd1 && !cond_w |=>
      out_count[LOOP_W-1:0] == LOOP_W'($past(in_count[LOOP_W-1:0]) - 1'b1));

  assert_trap_vector_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_trap |-> out_trap_vec == VEC_W'(TRAP_VEC));

  assert_reserved_false_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_illegal_pred |-> !out_cond && !out_trap);

endmodule

// File: tb/fpcond_unit_bench.sv
`timescale 1ns/1ps
module fpcond_unit_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [1:0]  in_op = '0;
  logic [5:0]  in_pred = '0;
  logic [3:0]  in_flags = '0;
  logic [31:0] in_count = '0;
  logic [2:0]  in_trap_mode = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic out_cond, out_take, out_trap, out_illegal_pred, out_bad_mode;
  logic [31:0] out_count;
  logic [7:0]  out_set_byte, out_trap_vec;
  logic [1:0]  out_skip_words;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int ready_mode = 0;

  always #2 clk = ~clk;

  fpcond_unit u_fpcond_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_pred(in_pred), .in_flags(in_flags), .in_count(in_count),
    .in_trap_mode(in_trap_mode), .out_valid(out_valid), .out_ready(out_ready),
    .out_cond(out_cond), .out_take(out_take), .out_count(out_count),
    .out_set_byte(out_set_byte), .out_trap(out_trap), .out_trap_vec(out_trap_vec),
    .out_skip_words(out_skip_words), .out_illegal_pred(out_illegal_pred),
    .out_bad_mode(out_bad_mode)
  );

  typedef struct {
    logic cond, take, trap, ill, bad;
    logic [31:0] cnt;
    logic [7:0] sb, vec;
    logic [1:0] skip;
    string tag;
  } exp_t;

  exp_t sb_q[$];

  function automatic logic ref_cond(input logic [5:0] p, input logic [3:0] f);
    logic nan, z, n;
    nan = f[0]; z = f[2]; n = f[3];
    if (p[5]) return 1'b0;
    case (p[3:0])
      4'h0: return 1'b0;
      4'h1: return z;
      4'h2: return ~(n | z | nan);
      4'h3: return z | (~n & ~nan);
      4'h4: return n & ~nan & ~z;
      4'h5: return z | (n & ~nan);
      4'h6: return ~nan & ~z;
      4'h7: return ~nan;
      4'h8: return nan;
      4'h9: return z | nan;
      4'hA: return nan | (~n & ~z);
      4'hB: return ~n | z | nan;
      4'hC: return nan | (n & ~z);
      4'hD: return n | z | nan;
      4'hE: return ~z;
      default: return 1'b1;
    endcase
  endfunction

  function automatic exp_t model(input logic [1:0] op, input logic [5:0] p,
                                 input logic [3:0] f, input logic [31:0] c,
                                 input logic [2:0] m, input string tag);
    exp_t e;
    logic [15:0] lo;
    e.cond = ref_cond(p, f);
    e.ill = p[5];
    e.take = 0; e.trap = 0; e.bad = 0; e.cnt = c; e.sb = 0; e.vec = 0; e.skip = 0;
    e.tag = tag;
    case (op)
      2'd0: e.take = e.cond;
      2'd1: if (!e.cond) begin
              lo = c[15:0] - 16'd1;
              e.cnt = {c[31:16], lo};
              e.take = (lo != 16'hFFFF);
            end
      2'd2: e.sb = e.cond ? 8'hFF : 8'h00;
      default: begin
        e.trap = e.cond;
        e.vec = e.cond ? 8'd7 : 8'd0;
        if (m == 3'd2) e.skip = 2'd1;
        else if (m == 3'd3) e.skip = 2'd2;
        else if (m != 3'd4) e.bad = 1'b1;
      end
    endcase
    return e;
  endfunction

  task automatic compare(input exp_t e, input string how);
    checks++;
    if (out_cond !== e.cond || out_take !== e.take || out_count !== e.cnt ||
        out_set_byte !== e.sb || out_trap !== e.trap || out_trap_vec !== e.vec ||
        out_skip_words !== e.skip || out_illegal_pred !== e.ill || out_bad_mode !== e.bad) begin
      fails++;
      $display("FAIL %s %s: got cond=%b take=%b cnt=%h sb=%h trap=%b vec=%0d skip=%0d ill=%b bad=%b exp cond=%b take=%b cnt=%h sb=%h trap=%b vec=%0d skip=%0d ill=%b bad=%b",
        e.tag, how, out_cond, out_take, out_count, out_set_byte, out_trap, out_trap_vec,
        out_skip_words, out_illegal_pred, out_bad_mode, e.cond, e.take, e.cnt, e.sb,
        e.trap, e.vec, e.skip, e.ill, e.bad);
    end
  endtask

  // One cycle: set consumer readiness, then act as the monitor.
  task automatic tick();
    @(negedge clk);
    cyc++;
    case (ready_mode)
      0: out_ready = 1'b1;
      1: out_ready = (cyc % 5) != 3;
      default: out_ready = (cyc % 3) == 0;
    endcase
    #1;
    if (out_valid) begin
      if (sb_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R12: out_valid=1 expected 0 (no request pending)");
      end else if (out_ready) begin
        compare(sb_q.pop_front(), "consumed");
      end else begin
        compare(sb_q[0], "R12 stalled");
      end
    end
  endtask

  task automatic send(input logic [1:0] op, input logic [5:0] p, input logic [3:0] f,
                      input logic [31:0] c, input logic [2:0] m, input string tag);
    in_op = op; in_pred = p; in_flags = f; in_count = c; in_trap_mode = m;
    in_valid = 1'b1;
    forever begin
      if (in_ready) begin
        sb_q.push_back(model(op, p, f, c, m, tag));
        tick();
        break;
      end
      tick();
    end
    in_valid = 1'b0;
  endtask

  function automatic string pred_tag(input logic [5:0] p);
    string t;
    if (p[5]) t = "R2";
    else if (p[3:0] inside {4'h0, 4'h1, 4'h7, 4'h8, 4'hE, 4'hF}) t = "R3";
    else if (p[3:0] inside {[4'h2:4'h6]}) t = "R4";
    else t = "R5";
    if (p[4]) t = {t, "/R1"};
    return t;
  endfunction

  initial begin : watchdog
    #(4 * 200000);
    checks++; fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    tick(); tick();
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      fails++;
      $display("FAIL R13: out_valid=%b in_ready=%b expected 0/1", out_valid, in_ready);
    end
    rst_n = 1'b1;
    tick();
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      fails++;
      $display("FAIL R13: after release out_valid=%b in_ready=%b expected 0/1", out_valid, in_ready);
    end

    // Full predicate/flag sweep through the set operation (R1-R5, R9).
    ready_mode = 0;
    for (int p = 0; p < 64; p++)
      for (int f = 0; f < 16; f++)
        send(2'd2, 6'(p), 4'(f), 32'h1234_5678, 3'd0, {pred_tag(6'(p)), "/R9"});

    // Branch under back-pressure (R6, R12).
    ready_mode = 1;
    for (int p = 0; p < 32; p++)
      send(2'd0, 6'(p), 4'(p * 7), 32'hCAFE_0000 + 32'(p), 3'd1, "R6/R12");

    // Loop counter cases (R7, R8).
    send(2'd1, 6'h01, 4'b0100, 32'hABCD_0005, 3'd0, "R7");
    send(2'd1, 6'h01, 4'b0000, 32'hABCD_0005, 3'd0, "R8");
    send(2'd1, 6'h01, 4'b0000, 32'hABCD_0000, 3'd0, "R8");
    send(2'd1, 6'h00, 4'b0000, 32'h0000_FFFF, 3'd0, "R8");
    send(2'd1, 6'h00, 4'b1111, 32'h8000_0001, 3'd0, "R8");
    send(2'd1, 6'h2F, 4'b0000, 32'h7777_0000, 3'd0, "R8/R2");
    send(2'd1, 6'h1F, 4'b0001, 32'h7777_0000, 3'd0, "R7/R1");

    // Trap modes with true and false conditions (R10, R11).
    ready_mode = 2;
    for (int m = 0; m < 8; m++) begin
      send(2'd3, 6'h0F, 4'b0000, 32'h0, 3'(m), "R10/R11");
      send(2'd3, 6'h00, 4'b0000, 32'h0, 3'(m), "R10/R11");
    end
    send(2'd3, 6'h08, 4'b0001, 32'h0, 3'd4, "R11");
    send(2'd3, 6'h28, 4'b0001, 32'h0, 3'd2, "R11/R2");

    ready_mode = 0;
    for (int i = 0; i < 20 && sb_q.size() != 0; i++) tick();
    checks++;
    if (sb_q.size() != 0) begin
      fails++;
      $display("FAIL R12: %0d results missing, expected 0", sb_q.size());
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule